// File: doc/BRIEF.md
# Microscaling Block Quantizer

This block takes a stream of bfloat16 numbers and turns every group of 32 consecutive values into one microscaled block. A block is made of one shared 8-bit scale and 32 narrow element codes. The scale holds only a biased power-of-two exponent, so each element's real value is its code's value multiplied by 2^(scale-127). For each group the block first stores all 32 inputs while it tracks the largest exponent. It then derives the shared scale and emits the group again, each value divided by the scale and rounded into the chosen element format.

A one-bit mode picks the element format for a group. Mode 0 gives a 4-bit float with one sign bit, two exponent bits and one mantissa bit. Mode 1 gives an 8-bit symmetric two's-complement integer. Both sides use valid/ready handshakes. Two group buffers alternate, so one group can be collected while the previous one is being emitted.

Top module: `mx_block_quant`

## Requirements
- R1: Each block leaves as 33 output beats: first a scale beat with `out_is_scale`=1, then 32 element beats with `out_is_scale`=0. `out_last`=1 only on the 32nd element beat, and the beat after it is the next block's scale beat.
- R2: Let M be the largest bfloat16 exponent field (bits 14:7) among the group's elements whose field is in 1..254. The scale code is M-2 in mode 0 and M-6 in mode 1, limited below at 0. The scale code s means a factor of 2^(s-127).
- R3: In mode 0 the element code is placed in `out_data[3:0]` with `out_data[7:4]`=0. Bit 3 is the sign, bits 2:1 the exponent and bit 0 the mantissa. Magnitude codes 0..7 stand for 0, 0.5, 1, 1.5, 2, 3, 4, 6. The scaled value x/2^(s-127) is rounded to the nearest magnitude, with ties going to the even code. Values above 6 become 6, and a zero result is always emitted as 0x0.
- R4: In mode 1 the element is k = x/2^(s-127), rounded to the nearest integer with ties to even. Its magnitude is limited to 127 and it is emitted in two's complement on `out_data[7:0]`, so 0x80 never appears.
- R5: If any element of a group has exponent field 255 (NaN or infinity), that block's scale beat is 0xFF. The block's element codes then carry no meaning.
- R6: An input with exponent field 0 (zero or subnormal) is treated as zero and gives element code 0x00. A group with no nonzero normal element gets scale 0x00 and all-zero elements.
- R7: The mode is taken from `in_mode` at a group's first element. `in_mode` on the other 31 elements has no effect on that block.
- R8: Element beats of a block appear in the order the inputs were accepted.
- R9: With the output stalled, exactly 64 inputs (two whole groups) are accepted before `in_ready` drops. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_is_scale` hold steady.
- R10: While reset is asserted and right after it, `out_valid`=0 and `in_ready`=1. Reset also discards any partly collected or pending groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input element offered |
| in_ready | output | 1 | Input element can be taken |
| in_data | input | 16 | bfloat16 input value |
| in_mode | input | 1 | Element format: 0 = 4-bit float, 1 = 8-bit integer |
| out_valid | output | 1 | Output beat offered |
| out_ready | input | 1 | Output beat taken by consumer |
| out_data | output | 8 | Scale code or element code |
| out_is_scale | output | 1 | Current beat is a scale word |
| out_last | output | 1 | Current beat is the final element of its block |

## Verification
The two functions that overlap in one cycle are collecting a new group into one buffer and emitting a finished group from the other. A further overlap is the writer finishing a group on the same edge that the reader releases the other buffer. These overlaps are provoked by streaming eleven groups back to back while both the producer and the consumer insert gaps on different periodic patterns, so that acceptance and emission shift against each other. Every emitted beat is then compared with a value the bench computes in real arithmetic, which shows that neither buffer corrupted the other. A separate stalled-output run shows that only two complete groups are held.

// File: rtl/mxq_pkg.sv
package mxq_pkg;
  localparam int          BF_W        = 16;
  localparam int          CODE_W      = 8;
  localparam logic [7:0]  SCALE_NAN   = 8'hFF;
  localparam int          FP4_EMAX    = 2;
  localparam int          INT8_EMAX   = 6;
  localparam int          FP4_TOP     = 7;
  localparam int          INT8_TOP    = 127;
  localparam int          SH_MAX      = 15;

  typedef enum logic { MODE_FP4 = 1'b0, MODE_INT8 = 1'b1 } mx_mode_e;

  function automatic logic [7:0] bf_exp(logic [BF_W-1:0] w);
    return w[14:7];
  endfunction

  function automatic int clamp_sh(int s);
    if (s < 1) return 1;
    if (s > SH_MAX) return SH_MAX;
    return s;
  endfunction

  // right shift of an 8-bit significand, round to nearest, ties to even
  function automatic logic [8:0] rne_shr(logic [7:0] sig, int sh);
    logic [15:0] wide, q, rem, half;
    wide = {8'b0, sig};
    q    = wide >> sh;
    rem  = wide & ((16'd1 << sh) - 16'd1);
    half = 16'd1 << (sh - 1);
    if ((rem > half) || ((rem == half) && q[0])) q = q + 16'd1;
    return q[8:0];
  endfunction

  function automatic logic [7:0] scale_of(logic nan, logic [7:0] maxe, mx_mode_e mode);
    int emax;
    emax = (mode == MODE_INT8) ? INT8_EMAX : FP4_EMAX;
    if (nan) return SCALE_NAN;
    if (int'(maxe) > emax) return maxe - 8'(emax);
    return 8'h00;
  endfunction

  function automatic logic [7:0] fp4_code(logic [BF_W-1:0] w, logic [7:0] scale);
    logic [8:0] n;
    logic [7:0] sig;
    int d, c;
    if (bf_exp(w) == 8'h00) return 8'h00;
    sig = {1'b1, w[6:0]};
    d   = int'(bf_exp(w)) - int'(scale);
    if (d >= 0) begin
      n = rne_shr(sig, 6);
      c = 2 * d + int'(n);
    end else begin
      n = rne_shr(sig, clamp_sh(6 - d));
      c = int'(n);
    end
    if (c > FP4_TOP) c = FP4_TOP;
    if (c == 0) return 8'h00;
    return {4'b0000, w[15], 3'(c)};
  endfunction

  function automatic logic [7:0] int8_code(logic [BF_W-1:0] w, logic [7:0] scale);
    logic [8:0] k;
    logic [7:0] mag;
    int d;
    if (bf_exp(w) == 8'h00) return 8'h00;
    d = int'(bf_exp(w)) - int'(scale);
    k = rne_shr({1'b1, w[6:0]}, clamp_sh(7 - d));
    if (k > 9'(INT8_TOP)) k = 9'(INT8_TOP);
    mag = k[7:0];
    return w[15] ? (8'h00 - mag) : mag;
  endfunction
endpackage

// File: rtl/mxq_conv.sv
module mxq_conv
  import mxq_pkg::*;
(
  input  logic [BF_W-1:0]   word,
  input  mx_mode_e          mode,
  input  logic [7:0]        scale,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] fp4_q, int_q;

  always_comb begin
    fp4_q = fp4_code(word, scale);
    int_q = int8_code(word, scale);
    code  = (mode == MODE_INT8) ? int_q : fp4_q;
  end
endmodule

// File: rtl/mxq_fill.sv
module mxq_fill
  import mxq_pkg::*;
#(
  parameter int BLK_LEN = 32,
  parameter int DATA_W  = BF_W,
  localparam int IDX_W  = $clog2(BLK_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_mode,
  input  logic              rd_buf,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              release_i,
  output logic [DATA_W-1:0] rd_word,
  output logic              rd_full,
  output mx_mode_e          rd_mode,
  output logic [7:0]        rd_maxe,
  output logic              rd_nan
);
  localparam int NBUF = 2;

  logic              wr_sel;
  logic [IDX_W-1:0]  wr_idx;
  logic [NBUF-1:0]   full;
  logic [DATA_W-1:0] mem [NBUF][BLK_LEN];
  mx_mode_e          bmode [NBUF];
  logic [7:0]        bmaxe [NBUF];
  logic              bnan  [NBUF];

  wire        accept    = in_valid && in_ready;
  wire        blk_first = accept && (wr_idx == '0);
  wire        blk_done  = accept && (wr_idx == IDX_W'(BLK_LEN - 1));
  wire [7:0]  in_e      = bf_exp(in_data);
  wire        in_is_nan = (in_e == SCALE_NAN);
  wire [7:0]  in_mag_e  = in_is_nan ? 8'h00 : in_e;

  assign in_ready = !full[wr_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_sel <= 1'b0;
      wr_idx <= '0;
    end else if (accept) begin
      wr_idx <= blk_done ? '0 : wr_idx + 1'b1;
      if (blk_done) wr_sel <= ~wr_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wr_sel][wr_idx] <= in_data;
  end

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    wire wr_here = accept && (wr_sel == 1'(b));

    always_ff @(posedge clk) begin
      if (!rst_n) full[b] <= 1'b0;
      else if (blk_done && wr_sel == 1'(b)) full[b] <= 1'b1;
      else if (release_i && rd_buf == 1'(b)) full[b] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (wr_here) begin
        if (blk_first) begin
          bmode[b] <= mx_mode_e'(in_mode);
          bmaxe[b] <= in_mag_e;
          bnan[b]  <= in_is_nan;
        end else begin
          if (in_mag_e > bmaxe[b]) bmaxe[b] <= in_mag_e;
          if (in_is_nan) bnan[b] <= 1'b1;
        end
      end
    end
  end

  assign rd_word = mem[rd_buf][rd_idx];
  assign rd_full = full[rd_buf];
  assign rd_mode = bmode[rd_buf];
  assign rd_maxe = bmaxe[rd_buf];
  assign rd_nan  = bnan[rd_buf];

  AST_READY_BOTH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (full == 2'b11)); // R9

  AST_READER_HOLDS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |-> rd_full); // R1
endmodule

// File: rtl/mxq_drain.sv
module mxq_drain
  import mxq_pkg::*;
#(
  parameter int BLK_LEN = 32,
  localparam int IDX_W  = $clog2(BLK_LEN),
  localparam int CNT_W  = $clog2(BLK_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BF_W-1:0]   rd_word,
  input  logic              rd_full,
  input  mx_mode_e          rd_mode,
  input  logic [7:0]        rd_maxe,
  input  logic              rd_nan,
  output logic              rd_buf,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              release_o,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CODE_W-1:0] out_data,
  output logic              out_is_scale,
  output logic              out_last
);
  logic [CNT_W-1:0]  cnt;
  logic [7:0]        blk_scale;
  logic [CODE_W-1:0] elem_code;

  wire at_scale = (cnt == '0);
  wire at_last  = (cnt == CNT_W'(BLK_LEN));
  wire fire     = out_valid && out_ready;

  assign blk_scale    = scale_of(rd_nan, rd_maxe, rd_mode);
  assign rd_idx       = at_scale ? '0 : IDX_W'(cnt - 1'b1);
  assign out_valid    = rd_full;
  assign out_is_scale = at_scale;
  assign out_last     = at_last;
  assign release_o    = fire && at_last;
  assign out_data     = at_scale ? blk_scale : elem_code;

  mxq_conv u_conv (
    .word  (rd_word),
    .mode  (rd_mode),
    .scale (blk_scale),
    .code  (elem_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      rd_buf <= 1'b0;
    end else if (fire) begin
      if (at_last) begin
        cnt    <= '0;
        rd_buf <= ~rd_buf;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_is_scale)); // R9

  AST_SCALE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid || out_is_scale); // R1

  AST_INT_SYMMETRIC: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_is_scale && rd_mode == MODE_INT8 |-> out_data != 8'h80); // R4

  AST_FP4_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_is_scale && rd_mode == MODE_FP4 |-> out_data[7:4] == 4'h0); // R3

  AST_NAN_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_is_scale && rd_nan |-> out_data == SCALE_NAN); // R5

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> rd_mode == $past(rd_mode)); // R7
endmodule

// File: rtl/mx_block_quant.sv
module mx_block_quant
  import mxq_pkg::*;
#(
  parameter int BLK_LEN = 32,
  localparam int IDX_W  = $clog2(BLK_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BF_W-1:0]   in_data,
  input  logic              in_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CODE_W-1:0] out_data,
  output logic              out_is_scale,
  output logic              out_last
);
  logic             rd_buf;
  logic [IDX_W-1:0] rd_idx;
  logic             release_w;
  logic [BF_W-1:0]  rd_word;
  logic             rd_full;
  mx_mode_e         rd_mode;
  logic [7:0]       rd_maxe;
  logic             rd_nan;

  mxq_fill #(.BLK_LEN(BLK_LEN), .DATA_W(BF_W)) u_fill (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_mode   (in_mode),
    .rd_buf    (rd_buf),
    .rd_idx    (rd_idx),
    .release_i (release_w),
    .rd_word   (rd_word),
    .rd_full   (rd_full),
    .rd_mode   (rd_mode),
    .rd_maxe   (rd_maxe),
    .rd_nan    (rd_nan)
  );

  mxq_drain #(.BLK_LEN(BLK_LEN)) u_drain (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_word      (rd_word),
    .rd_full      (rd_full),
    .rd_mode      (rd_mode),
    .rd_maxe      (rd_maxe),
    .rd_nan       (rd_nan),
    .rd_buf       (rd_buf),
    .rd_idx       (rd_idx),
    .release_o    (release_w),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .out_is_scale (out_is_scale),
    .out_last     (out_last)
  );
endmodule

// File: tb/sim_mx_block_quant.sv
module sim_mx_block_quant;
  localparam int CLK_PERIOD = 10;
  localparam int BL   = 32;
  localparam int BEAT = BL + 1;
  localparam int NV   = 11;
  // {mode, kind, base exponent, seed}
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 3'd0, 8'd130, 8'd3},
    {1'b1, 3'd0, 8'd120, 8'd5},
    {1'b0, 3'd3, 8'd127, 8'd0},
    {1'b1, 3'd6, 8'd127, 8'd0},
    {1'b0, 3'd4, 8'd2,   8'd1},
    {1'b1, 3'd4, 8'd3,   8'd2},
    {1'b0, 3'd1, 8'd0,   8'd0},
    {1'b1, 3'd2, 8'd127, 8'd9},
    {1'b0, 3'd5, 8'd140, 8'd4},
    {1'b1, 3'd3, 8'd100, 8'd0},
    {1'b0, 3'd6, 8'd90,  8'd7}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_mode = 1'b0, out_ready = 1'b0;
  logic [15:0] in_data = 16'h0;
  logic in_ready, out_valid, out_is_scale, out_last;
  logic [7:0] out_data;

  int tests = 0, fails = 0;
  bit done = 1'b0, timeout = 1'b0;

  logic [15:0] s_data [NV*BL];
  logic        s_mode [NV*BL];
  logic [7:0]  cap    [NV*BEAT];
  logic [7:0]  e_scale [NV];
  logic [7:0]  e_el    [NV*BL];
  bit          e_nan   [NV];

  always #(CLK_PERIOD/2) clk = ~clk;

  mx_block_quant u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_mode(in_mode), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_is_scale(out_is_scale),
    .out_last(out_last)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic real pow2(int n);
    real r = 1.0;
    if (n >= 0) for (int i = 0; i < n; i++) r = r * 2.0;
    else for (int i = 0; i < -n; i++) r = r / 2.0;
    return r;
  endfunction

  function automatic real bf2real(logic [15:0] w);
    real r;
    if (w[14:7] == 8'd0) return 0.0;
    r = (1.0 + w[6:0] / 128.0) * pow2(int'(w[14:7]) - 127);
    return w[15] ? -r : r;
  endfunction

  function automatic real fp4_mag(int k);
    case (k)
      0: return 0.0; 1: return 0.5; 2: return 1.0; 3: return 1.5;
      4: return 2.0; 5: return 3.0; 6: return 4.0; default: return 6.0;
    endcase
  endfunction

  function automatic logic [7:0] model_fp4(real v);
    real a, bd, dd;
    int best;
    a = (v < 0.0) ? -v : v;
    best = 0; bd = a;
    for (int k = 1; k < 8; k++) begin
      dd = a - fp4_mag(k);
      if (dd < 0.0) dd = -dd;
      if ((dd < bd) || ((dd == bd) && (k % 2 == 0))) begin best = k; bd = dd; end
    end
    if (a > 6.0) best = 7;
    if (best == 0) return 8'h00;
    return {4'b0000, (v < 0.0), 3'(best)};
  endfunction

  function automatic logic [7:0] model_int8(real v);
    real a, f, fr;
    int ki;
    a = (v < 0.0) ? -v : v;
    f = $floor(a); fr = a - f; ki = $rtoi(f);
    if (fr > 0.5) ki++;
    else if ((fr == 0.5) && (ki % 2 == 1)) ki++;
    if (ki > 127) ki = 127;
    return (v < 0.0) ? 8'(-ki) : 8'(ki);
  endfunction

  function automatic logic [15:0] gen(int kind, int base, int seed, int i);
    int e, m;
    bit s;
    s = ((i * 5 + seed) % 3) == 0;
    e = base + ((i * 7 + seed) % 5) - 2;
    m = (i * 37 + seed * 11) % 128;
    case (kind)
      1: return (i % 2) ? 16'h8000 : 16'h0000;
      2: if (i == seed % BL) return 16'h7FC1;
      3: begin e = base - (i % 3); m = (i % 4) * 32; s = ((i >> 2) % 2) == 1; end
      4: begin e = base - (i % 3); if (e < 0) e = 0; m = (i * 13) % 128; end
      5: if (i % 4 == 0) begin e = 0; m = (i * 3) % 128; end
      6: begin e = base - (i % 4); m = 1 << (i % 7); s = (i % 2) == 1; end
      default: ;
    endcase
    return {s, 8'(e), 7'(m)};
  endfunction

  task automatic build_expect(input int b);
    int maxe, emax, sc;
    bit nan, md;
    real v;
    md = VEC[b][19];
    maxe = 0; nan = 1'b0;
    for (int i = 0; i < BL; i++) begin
      s_data[b*BL+i] = gen(int'(VEC[b][18:16]), int'(VEC[b][15:8]), int'(VEC[b][7:0]), i);
      s_mode[b*BL+i] = (i % 2 == 1) ? ~md : md;   // R7: later modes must be ignored
      if (s_data[b*BL+i][14:7] == 8'hFF) nan = 1'b1;
      else if (int'(s_data[b*BL+i][14:7]) > maxe) maxe = int'(s_data[b*BL+i][14:7]);
    end
    emax = md ? 6 : 2;
    sc = (maxe > emax) ? maxe - emax : 0;
    e_nan[b] = nan;
    e_scale[b] = nan ? 8'hFF : 8'(sc);
    for (int i = 0; i < BL; i++) begin
      v = bf2real(s_data[b*BL+i]) / pow2(sc - 127);
      e_el[b*BL+i] = md ? model_int8(v) : model_fp4(v);
    end
  endtask

  task automatic run_stream(input int nb, input bit stall);
    int ptr, beat, cyc;
    ptr = 0; beat = 0; cyc = 0;
    while (beat < nb * BEAT && !timeout) begin
      @(negedge clk);
      in_valid  = (ptr < nb * BL) && !(stall && (cyc % 7 == 3));
      in_data   = (ptr < nb * BL) ? s_data[ptr] : 16'h0;
      in_mode   = (ptr < nb * BL) ? s_mode[ptr] : 1'b0;
      out_ready = !(stall && ((cyc % 5 == 1) || (cyc % 11 == 4)));
      #1;
      if (out_valid && out_ready) begin
        chk($sformatf("R1 scale flag beat %0d", beat), {7'b0, out_is_scale}, {7'b0, (beat % BEAT) == 0});
        chk($sformatf("R1 last flag beat %0d", beat), {7'b0, out_last}, {7'b0, (beat % BEAT) == BL});
        cap[beat] = out_data;
        beat++;
      end
      if (in_valid && in_ready) ptr++;
      cyc++;
      if (cyc > 50000) begin
        timeout = 1'b1;
        fails++;
        $display("FAIL R1 stream stuck actual %0d beats expected %0d", beat, nb * BEAT);
      end
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual running expected finished");
      finish_run();
    end
  end

  initial begin
    int acc;
    logic [7:0] held;
    string tag;
    for (int b = 0; b < NV; b++) build_expect(b);

    // R10: state during and after reset
    repeat (3) @(negedge clk);
    chk("R10 out_valid in reset", {7'b0, out_valid}, 8'h00);
    chk("R10 in_ready in reset", {7'b0, in_ready}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R10 out_valid after reset", {7'b0, out_valid}, 8'h00);
    chk("R10 in_ready after reset", {7'b0, in_ready}, 8'h01);

    // table walk: all blocks streamed with gaps on both sides
    run_stream(NV, 1'b1);
    for (int b = 0; b < NV; b++) begin
      tag = e_nan[b] ? "R5" : (VEC[b][18:16] == 3'd1 ? "R6" : "R2");
      chk($sformatf("%s scale blk%0d", tag, b), cap[b*BEAT], e_scale[b]);
      if (!e_nan[b])
        for (int i = 0; i < BL; i++) begin
          tag = VEC[b][18:16] inside {3'd1, 3'd5} ? "R6" : (VEC[b][19] ? "R4" : "R3");
          chk($sformatf("%s R7 R8 blk%0d el%0d", tag, b, i), cap[b*BEAT+1+i], e_el[b*BL+i]);
        end
    end

    // R9: stalled output holds exactly two groups and keeps its beat steady
    acc = 0;
    for (int c = 0; c < 90; c++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data = s_data[acc % (2*BL)];
      in_mode = s_mode[acc % (2*BL)];
      out_ready = 1'b0;
      #1;
      if (c == 80) held = out_data;
      if (in_valid && in_ready) acc++;
    end
    chk("R9 inputs taken while stalled", 8'(acc), 8'd64);
    chk("R9 in_ready low when full", {7'b0, in_ready}, 8'h00);
    chk("R9 out_valid while stalled", {7'b0, out_valid}, 8'h01);
    chk("R9 stalled beat is scale", {7'b0, out_is_scale}, 8'h01);
    chk("R9 stalled data steady", out_data, held);
    chk("R2 stalled scale value", out_data, e_scale[0]);

    // R10: reset in the middle of traffic drops pending groups
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk); #1;
    chk("R10 out_valid after mid reset", {7'b0, out_valid}, 8'h00);
    chk("R10 in_ready after mid reset", {7'b0, in_ready}, 8'h01);
    rst_n = 1'b1;

    // after reset, a single stream of the first two groups without gaps
    timeout = 1'b0;
    run_stream(2, 1'b0);
    for (int b = 0; b < 2; b++) begin
      chk($sformatf("R2 rerun scale blk%0d", b), cap[b*BEAT], e_scale[b]);
      for (int i = 0; i < BL; i++)
        chk($sformatf("R8 rerun blk%0d el%0d", b, i), cap[b*BEAT+1+i], e_el[b*BL+i]);
    end
    finish_run();
  end
endmodule